// File: doc/BRIEF.md
# Load-Store Byte-Lane Alignment Unit

This unit sits between a processor's execute stage and a 32-bit, word-addressed data memory. For every access it forms the effective address by adding a base register to a sign-extended 16-bit displacement. It then issues one registered memory request that carries the word address, per-byte write enables and the steered write data. When a load word returns from memory, the unit picks out the addressed byte, halfword or word and widens it to 32 bits, using sign or zero extension as the request asks.

Byte order is little-endian. Address bits 1:0 select the byte lane, and address bit 1 selects the halfword. A halfword access at an odd address, or a word access that is not on a four-byte boundary, gets no memory request. The unit raises an alignment error instead. Loads may be issued on every cycle: a small in-order queue keeps the lane and extension choice of each load until its data comes back.

Access size code on `req_size`: 00 byte, 01 halfword, 10 word, 11 also word.

Top module: `lsu_lane_align`

## Requirements
- R1: One cycle after a request is accepted, `mem_addr` equals bits 31:2 of `req_base` plus the sign-extended `req_offset`. This includes offsets with bit 15 set and sums that carry above bit 15.
- R2: A byte store asserts only the enable bit numbered by address bits 1:0. `mem_wdata` carries source bits 7:0 copied into all four lanes.
- R3: A halfword store enables lanes 1:0 (`mem_be` = 0011) when address bit 1 is 0, and lanes 3:2 (1100) when it is 1. `mem_wdata` carries source bits 15:0 in both halves.
- R4: A word store (size 10 or 11) asserts all four enables and writes the source unchanged.
- R5: A load raises `mem_req` with `mem_write` low. `mem_be` marks the lanes the load reads, using the same lane rules as a store of that size.
- R6: A byte load returns the addressed lane. It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R7: A halfword load returns the half chosen by address bit 1. It is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R8: A word load returns all 32 bits unchanged, and `req_unsigned` has no effect on it.
- R9: A halfword request with address bit 0 set, or a word request with either low address bit set, produces `align_err` high and `mem_req` low one cycle later. It writes nothing to memory and yields no `ld_valid`. A byte request never raises the error.
- R10: `ld_valid` rises one cycle after `mem_rvalid`. Loads issued on consecutive cycles complete in issue order, each with its own lane and extension.
- R11: While reset is asserted and on the first cycle after it is released, `mem_req`, `align_err` and `ld_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 00 byte, 01 half, 10/11 word |
| req_unsigned | input | 1 | Zero-extend loaded byte or half |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_req | output | 1 | Memory access strobe |
| mem_write | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Per-lane byte enables |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned memory word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |
| align_err | output | 1 | Misaligned access rejected |

## Verification
The hardest state to reach is the load format queue holding two entries. That happens when a new load is issued in the same cycle as an older load's data returns, and a rejected misaligned request is mixed into the same stream. The stimulus does this by issuing loads on back-to-back cycles to different lanes, mixing signed and unsigned, with misaligned and store requests slipped between them. Every returned value must then match the format of its own load. A misaligned store is followed by a load of the same word, which shows at the ports that the memory was left untouched.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } size_e;

  typedef struct packed {
    logic [1:0] lane;
    size_e      size;
    logic       zext;
  } ld_fmt_t;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input  logic [XLEN-1:0] base,
  input  logic [OFFW-1:0] offset,
  input  size_e           size,
  output logic [XLEN-1:0] ea,
  output logic            misalign
);
  localparam int EXTW = XLEN - OFFW;

  always_comb begin
    ea = base + {{EXTW{offset[OFFW-1]}}, offset};
    unique case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = ea[0];
      default: misalign = |ea[1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]        lane,
  input  size_e             size,
  input  logic [XLEN-1:0]   src,
  output logic [XLEN/8-1:0] be,
  output logic [XLEN-1:0]   wdata
);
  localparam int LANES = XLEN / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[i]          = (lane == 2'(i));
          wdata[8*i +: 8] = src[7:0];
        end
        SZ_HALF: begin
          be[i]          = (lane[1] == i[1]);
          wdata[8*i +: 8] = src[8*(i%2) +: 8];
        end
        default: begin
          be[i]          = 1'b1;
          wdata[8*i +: 8] = src[8*i +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ld_fmt_t         fmt,
  input  logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] result
);
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;

  always_comb begin
    byte_sel = rdata[{fmt.lane, 3'b000} +: 8];
    half_sel = rdata[{fmt.lane[1], 4'b0000} +: 16];
    unique case (fmt.size)
      SZ_BYTE: result = fmt.zext ? {{(XLEN-8){1'b0}}, byte_sel}
                                 : {{(XLEN-8){byte_sel[7]}}, byte_sel};
      SZ_HALF: result = fmt.zext ? {{(XLEN-16){1'b0}}, half_sel}
                                 : {{(XLEN-16){half_sel[15]}}, half_sel};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_fmt_fifo.sv
module lsu_fmt_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push ? wrap_inc(wr_q) : wr_q;
    rd_d  = pop  ? wrap_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store_q[wr_q] <= din;
  end

  assign dout  = store_q[rd_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  p_push_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  p_pop_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int OFFW      = 16,
  parameter int FMT_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_store,
  input  logic [1:0]         req_size,
  input  logic               req_unsigned,
  input  logic [XLEN-1:0]    req_base,
  input  logic [OFFW-1:0]    req_offset,
  input  logic [XLEN-1:0]    req_wdata,
  output logic               mem_req,
  output logic               mem_write,
  output logic [XLEN-3:0]    mem_addr,
  output logic [XLEN/8-1:0]  mem_be,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic               mem_rvalid,
  input  logic [XLEN-1:0]    mem_rdata,
  output logic               ld_valid,
  output logic [XLEN-1:0]    ld_data,
  output logic               align_err
);
  localparam int LANES = XLEN / 8;
  localparam int LB    = $clog2(LANES);
  localparam int FW    = $bits(ld_fmt_t);

  size_e             size;
  logic [XLEN-1:0]   ea;
  logic              misalign;
  logic [LANES-1:0]  lane_be;
  logic [XLEN-1:0]   lane_wd;
  ld_fmt_t           fmt_in, fmt_out;
  logic [FW-1:0]     fmt_raw;
  logic              fmt_full, fmt_empty;
  logic [XLEN-1:0]   ld_fmt_data;

  logic              issue, reject, push_fmt;
  logic              req_d, write_d, err_d, ldv_d;
  logic [XLEN-3:0]   addr_d;
  logic [LANES-1:0]  be_d;
  logic              req_q, write_q, err_q, ldv_q;
  logic [XLEN-3:0]   addr_q;
  logic [LANES-1:0]  be_q;
  logic [XLEN-1:0]   wdata_q, ldd_q;

  assign size = size_e'(req_size);

  lsu_addr_gen #(.XLEN(XLEN), .OFFW(OFFW)) u_agen (
    .base(req_base), .offset(req_offset), .size(size),
    .ea(ea), .misalign(misalign)
  );

  lsu_store_steer #(.XLEN(XLEN)) u_steer (
    .lane(ea[1:0]), .size(size), .src(req_wdata),
    .be(lane_be), .wdata(lane_wd)
  );

  assign fmt_in = '{lane: ea[1:0], size: size, zext: req_unsigned};

  lsu_fmt_fifo #(.WIDTH(FW), .DEPTH(FMT_DEPTH)) u_fmtq (
    .clk(clk), .rst_n(rst_n),
    .push(push_fmt), .din(fmt_in),
    .pop(mem_rvalid), .dout(fmt_raw),
    .full(fmt_full), .empty(fmt_empty)
  );

  assign fmt_out = ld_fmt_t'(fmt_raw);

  lsu_load_fmt #(.XLEN(XLEN)) u_lfmt (
    .fmt(fmt_out), .rdata(mem_rdata), .result(ld_fmt_data)
  );

  // next-state
  always_comb begin
    issue    = req_valid && !misalign;
    reject   = req_valid && misalign;
    push_fmt = issue && !req_store;
    req_d    = issue;
    write_d  = issue && req_store;
    err_d    = reject;
    addr_d   = ea[XLEN-1:LB];
    be_d     = issue ? lane_be : '0;
    ldv_d    = mem_rvalid;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      write_q <= 1'b0;
      err_q   <= 1'b0;
      ldv_q   <= 1'b0;
      be_q    <= '0;
    end else begin
      req_q   <= req_d;
      write_q <= write_d;
      err_q   <= err_d;
      ldv_q   <= ldv_d;
      be_q    <= be_d;
    end
  end

  // data registers, clock-enabled
  always_ff @(posedge clk) begin
    if (req_valid) begin
      addr_q  <= addr_d;
      wdata_q <= lane_wd;
    end
    if (mem_rvalid) begin
      ldd_q <= ld_fmt_data;
    end
  end

  assign mem_req   = req_q;
  assign mem_write = write_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wdata_q;
  assign align_err = err_q;
  assign ld_valid  = ldv_q;
  assign ld_data   = ldd_q;

  p_err_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && mem_be == '0));
  p_write_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_write) |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
       $countones(mem_be) == LANES));
  p_rvalid_to_ld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |=> ld_valid);
  p_ld_needs_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_rvalid));
  p_rvalid_has_fmt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !fmt_empty);
  p_reject_pushes_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !mem_req);
endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk, rst_n;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_offset;
  logic        mem_req, mem_write, mem_rvalid, ld_valid, align_err;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata, ld_data;

  typedef struct {
    string       tag;
    bit          err;
    bit          wr;
    logic [29:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
  } req_item_t;

  typedef struct {
    string       tag;
    logic [31:0] data;
  } ld_item_t;

  req_item_t   rq[$];
  ld_item_t    lq[$];
  logic [31:0] mem    [16];
  logic [31:0] shadow [16];
  int          vecs  = 0;
  int          fails = 0;
  bit          done  = 0;

  lsu_lane_align u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .req_unsigned(req_unsigned), .req_base(req_base), .req_offset(req_offset),
    .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .align_err(align_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: one-cycle read latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= mem_req && !mem_write;
      mem_rdata  <= mem[mem_addr[3:0]];
      if (mem_req && mem_write)
        for (int i = 0; i < 4; i++)
          if (mem_be[i]) mem[mem_addr[3:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_req || align_err) begin
        if (rq.size() == 0) begin
          check("R9", "unexpected request", {30'b0, mem_req, align_err}, 32'h0);
        end else begin
          req_item_t it;
          it = rq.pop_front();
          if (it.err) begin
            check(it.tag, "align_err", {31'b0, align_err}, 32'h1);
            check(it.tag, "mem_req on error", {31'b0, mem_req}, 32'h0);
          end else begin
            check(it.tag, "align_err", {31'b0, align_err}, 32'h0);
            check(it.tag, "mem_write", {31'b0, mem_write}, {31'b0, it.wr});
            check(it.tag, "mem_addr", {2'b0, mem_addr}, {2'b0, it.addr});
            check(it.tag, "mem_be", {28'b0, mem_be}, {28'b0, it.be});
            if (it.wr) check(it.tag, "mem_wdata", mem_wdata, it.wdata);
          end
        end
      end
      if (ld_valid) begin
        if (lq.size() == 0) begin
          check("R10", "unexpected ld_valid", 32'h1, 32'h0);
        end else begin
          ld_item_t li;
          li = lq.pop_front();
          check(li.tag, "ld_data", ld_data, li.data);
        end
      end
    end
  end

  // driver: one request per call, at a falling edge
  task automatic access(input bit st, input logic [1:0] sz, input bit uns,
                        input logic [31:0] base, input logic [15:0] off,
                        input logic [31:0] src, input string tag);
    logic [31:0] ea, w, res;
    logic [3:0]  be;
    logic [31:0] wd;
    bit          err;
    req_item_t   it;
    ld_item_t    li;
    ea  = base + {{16{off[15]}}, off};
    err = (sz == 2'd1) ? ea[0] : (sz >= 2'd2) ? (ea[1:0] != 2'b00) : 1'b0;
    case (sz)
      2'd0:    begin be = 4'b0001 << ea[1:0]; wd = {4{src[7:0]}}; end
      2'd1:    begin be = ea[1] ? 4'b1100 : 4'b0011; wd = {2{src[15:0]}}; end
      default: begin be = 4'b1111; wd = src; end
    endcase
    it = '{tag: tag, err: err, wr: st, addr: ea[31:2], be: be, wdata: wd};
    rq.push_back(it);
    if (!err) begin
      if (st) begin
        for (int i = 0; i < 4; i++)
          if (be[i]) shadow[ea[5:2]][8*i +: 8] = wd[8*i +: 8];
      end else begin
        w = shadow[ea[5:2]];
        case (sz)
          2'd0: begin
            res = {24'b0, w[8*ea[1:0] +: 8]};
            if (!uns && res[7]) res[31:8] = '1;
          end
          2'd1: begin
            res = {16'b0, w[16*ea[1] +: 16]};
            if (!uns && res[15]) res[31:16] = '1;
          end
          default: res = w;
        endcase
        li = '{tag: tag, data: res};
        lq.push_back(li);
      end
    end
    @(negedge clk);
    req_valid    = 1'b1;
    req_store    = st;
    req_size     = sz;
    req_unsigned = uns;
    req_base     = base;
    req_offset   = off;
    req_wdata    = src;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<%0d", WATCHDOG, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]    = 32'hA5A5_0000 | i;
      shadow[i] = 32'hA5A5_0000 | i;
    end
    mem[2]    = 32'h80FF_7F01;  shadow[2] = 32'h80FF_7F01;
    mem[3]    = 32'h8001_7FFE;  shadow[3] = 32'h8001_7FFE;
    req_valid = 0; req_store = 0; req_size = 0; req_unsigned = 0;
    req_base = 0; req_offset = 0; req_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: outputs idle during reset
    check("R11", "reset mem_req", {31'b0, mem_req}, 32'h0);
    check("R11", "reset align_err", {31'b0, align_err}, 32'h0);
    check("R11", "reset ld_valid", {31'b0, ld_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "post-reset mem_req", {31'b0, mem_req}, 32'h0);
    check("R11", "post-reset ld_valid", {31'b0, ld_valid}, 32'h0);

    // R4: word stores, size 10 and 11
    access(1, 2'd2, 0, 32'h0000_0000, 16'h0000, 32'h1122_3344, "R4");
    access(1, 2'd3, 0, 32'h0000_0014, 16'hFFFC, 32'hCAFE_F00D, "R4");
    // R2: byte stores to each lane of word 1
    for (int l = 0; l < 4; l++)
      access(1, 2'd0, 0, 32'h0000_0004, 16'(l), 32'hFFFF_FF00 | (l * 17 + 3), "R2");
    // R3: halfword stores, both halves of word 4
    access(1, 2'd1, 0, 32'h0000_0010, 16'h0000, 32'hDEAD_8123, "R3");
    access(1, 2'd1, 0, 32'h0000_0010, 16'h0002, 32'hBEEF_7456, "R3");
    idle(3);

    // R6: byte loads back to back, signed and unsigned, every lane
    for (int l = 0; l < 4; l++) begin
      access(0, 2'd0, 0, 32'h0000_0008, 16'(l), 32'h0, "R6");
      access(0, 2'd0, 1, 32'h0000_0008, 16'(l), 32'h0, "R6");
    end
    // R7: halfword loads, both halves, both extensions
    access(0, 2'd1, 0, 32'h0000_000C, 16'h0000, 32'h0, "R7");
    access(0, 2'd1, 1, 32'h0000_000C, 16'h0000, 32'h0, "R7");
    access(0, 2'd1, 0, 32'h0000_000C, 16'h0002, 32'h0, "R7");
    access(0, 2'd1, 1, 32'h0000_000C, 16'h0002, 32'h0, "R7");
    // R8: word loads, extension flag ignored
    access(0, 2'd2, 1, 32'h0000_0008, 16'h0000, 32'h0, "R8");
    access(0, 2'd2, 0, 32'h0000_000C, 16'h0000, 32'h0, "R8");
    // R5: read back stored data, loads interleaved with a store
    access(0, 2'd2, 0, 32'h0000_0000, 16'h0000, 32'h0, "R5");
    access(1, 2'd0, 0, 32'h0000_0018, 16'h0001, 32'h0000_0077, "R2");
    access(0, 2'd2, 0, 32'h0000_0004, 16'h0000, 32'h0, "R5");
    access(0, 2'd2, 0, 32'h0000_0010, 16'h0000, 32'h0, "R5");
    access(0, 2'd1, 0, 32'h0000_0018, 16'h0000, 32'h0, "R5");
    idle(3);

    // R1: negative offset and carry past bit 15
    access(0, 2'd2, 0, 32'h0000_8030, 16'h8000, 32'h0, "R1");
    access(0, 2'd0, 1, 32'h0001_0010, 16'h8005, 32'h0, "R1");
    access(1, 2'd2, 0, 32'h1234_0040, 16'hFFF8, 32'h5555_AAAA, "R1");
    idle(3);

    // R9: misaligned requests between loads; stores leave memory alone
    access(0, 2'd0, 0, 32'h0000_0008, 16'h0003, 32'h0, "R10");
    access(1, 2'd1, 0, 32'h0000_0008, 16'h0001, 32'hFFFF_FFFF, "R9");
    access(0, 2'd1, 0, 32'h0000_0008, 16'h0002, 32'h0, "R10");
    access(1, 2'd2, 0, 32'h0000_000C, 16'h0002, 32'hFFFF_FFFF, "R9");
    access(0, 2'd2, 0, 32'h0000_000C, 16'h0003, 32'h0, "R9");
    access(0, 2'd3, 0, 32'h0000_000C, 16'h0001, 32'h0, "R9");
    access(0, 2'd1, 1, 32'h0000_000C, 16'h0003, 32'h0, "R9");
    access(0, 2'd0, 1, 32'h0000_0008, 16'h0001, 32'h0, "R9");
    access(0, 2'd2, 0, 32'h0000_0008, 16'h0000, 32'h0, "R9");
    access(0, 2'd2, 0, 32'h0000_000C, 16'h0000, 32'h0, "R9");
    idle(6);

    check("R10", "pending requests", rq.size(), 32'h0);
    check("R10", "pending loads", lq.size(), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule